// File: doc/BRIEF.md
# Command-Keyed Windowed Watchdog Timer

This block is a watchdog peripheral that sits on a simple 32-bit register bus with address, write enable, write data and read data. A prescaler divides the core clock by a programmable divisor to form a counting tick. While the watchdog runs, a 32-bit up-counter advances on every tick. When it reaches a programmable upper limit, the block raises a one-cycle timeout pulse.

The watchdog cannot be started, stopped or refreshed by an ordinary register write. Each of these actions needs a specific 16-bit code written to a command register, and a mode bit selects whether the run code starts or stops the watchdog. A lower window bound can also be programmed. A refresh that arrives too early, while the count is still below that bound, counts as a fault in the supervised software and triggers the timeout at once.

Software refreshes the counter before it loads a smaller limit, and it can read the count at any time to work out the time left as limit minus count. Register offsets: count 0x00, window low 0x04, limit 0x08, mode/status 0x0C, command 0x10, divisor 0x30.

Top module: `wdt_magic`

## Requirements
- R1: After reset every register reads 0, the watchdog is stopped and `timeout_pulse` is low.
- R2: Window low (0x04), limit (0x08) and divisor (0x30) read back exactly what was written. The mode/status register (0x0C) keeps only bit 0, the mode bit. The command register (0x10) and unmapped offsets read 0.
- R3: Writing exactly 0x00005354 to 0x10 while mode bit 0 is 0 starts the watchdog. It also clears the count, the prescaler and the expired flag. The same write while mode bit 0 is 1 stops the watchdog, and the count then holds its value.
- R4: While the watchdog runs, the count rises by one every D clocks after a start or refresh, where D is the divisor. A divisor of 0 or 1 gives one step per clock.
- R5: Expiry happens when a step makes the count equal to or greater than the limit. The count then holds that value, and `timeout_pulse` is high for exactly one cycle.
- R6: Bit 31 of 0x0C is a sticky expired flag. It is set on every expiry and is cleared only by a start.
- R7: Writing exactly 0x00004352 to 0x10 clears the count and the prescaler. If the watchdog had expired while running, counting resumes.
- R8: A refresh that arrives while the watchdog is running and not expired, with a non-zero window low and a count below it, is a window violation. It pulses `timeout_pulse`, sets the expired flag and leaves the count unchanged.
- R9: A window low of 0 disables the violation check, so a refresh at any count clears the counter.
- R10: Any value written to 0x10 other than the two exact codes changes neither the count nor the run state.
- R11: The count is readable at 0x00 at all times, and writes to 0x00 are ignored.
- R12: If the limit is lowered below the current count without a refresh, the watchdog expires at the next step. If the counter is refreshed first, it does not expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timeout_pulse | output | 1 | One-cycle expiry pulse |

## Verification
A write or command takes effect at the rising edge that samples it. Read data is combinational, so a value written at an edge is visible just after that edge. With a divisor D, the count steps at the edges D, 2D and so on after the edge that captured a start or refresh. `timeout_pulse` is high during the cycle that follows the edge of the expiring step, or the edge of the violating refresh. The bench drives inputs at falling edges and samples one nanosecond later. It counts the falling edges from the capture edge of each command, so every expected count and pulse is checked in the exact cycle it becomes due.

// File: rtl/wdt_magic.sv
module wdt_magic #(
  parameter int          AW       = 8,
  parameter int          DW       = 32,
  parameter int          PW       = 32,
  parameter logic [15:0] CLR_CODE = 16'h4352,
  parameter logic [15:0] RUN_CODE = 16'h5354
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          timeout_pulse
);
  localparam logic [AW-1:0] A_CNT = AW'(8'h00);
  localparam logic [AW-1:0] A_MIN = AW'(8'h04);
  localparam logic [AW-1:0] A_MAX = AW'(8'h08);
  localparam logic [AW-1:0] A_CTL = AW'(8'h0C);
  localparam logic [AW-1:0] A_CMD = AW'(8'h10);
  localparam logic [AW-1:0] A_DIV = AW'(8'h30);
  localparam logic [DW-1:0] CLR_W = DW'(CLR_CODE);
  localparam logic [DW-1:0] RUN_W = DW'(RUN_CODE);

  logic [DW-1:0] cnt_q, wmin_q, wmax_q;
  logic [PW-1:0] div_q, pre_q;
  logic          mode_q, running_q, halt_q, expired_q;

  logic wr_cmd, cmd_clr, cmd_run, do_start, do_stop, active, tick, hit, viol, expire_evt;
  logic [DW:0] cnt_inc;

  assign wr_cmd   = bus_we && (bus_addr == A_CMD);
  assign cmd_clr  = wr_cmd && (bus_wdata == CLR_W);
  assign cmd_run  = wr_cmd && (bus_wdata == RUN_W);
  assign do_start = cmd_run && !mode_q;
  assign do_stop  = cmd_run && mode_q;
  assign active   = running_q && !halt_q;
  assign tick     = active && ((div_q <= PW'(1)) || (pre_q == div_q - PW'(1)));
  assign cnt_inc  = {1'b0, cnt_q} + (DW+1)'(1);
  assign hit      = tick && (cnt_inc >= {1'b0, wmax_q});
  assign viol     = cmd_clr && active && (wmin_q != '0) && (cnt_q < wmin_q);
  assign expire_evt = viol || (hit && !cmd_clr && !cmd_run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmin_q <= '0;
      wmax_q <= '0;
      div_q  <= '0;
      mode_q <= 1'b0;
    end else if (bus_we) begin
      if (bus_addr == A_MIN) wmin_q <= bus_wdata;
      if (bus_addr == A_MAX) wmax_q <= bus_wdata;
      if (bus_addr == A_DIV) div_q  <= PW'(bus_wdata);
      if (bus_addr == A_CTL) mode_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (do_start || (cmd_clr && !viol))
        cnt_q <= '0;
      else if (tick && !do_stop && !viol)
        cnt_q <= cnt_inc[DW-1:0];

      if (do_start || do_stop || cmd_clr || tick)
        pre_q <= '0;
      else if (active)
        pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q     <= 1'b0;
      halt_q        <= 1'b0;
      expired_q     <= 1'b0;
      timeout_pulse <= 1'b0;
    end else begin
      timeout_pulse <= expire_evt;
      if (do_start)     running_q <= 1'b1;
      else if (do_stop) running_q <= 1'b0;
      if (do_start || do_stop || (cmd_clr && !viol)) halt_q <= 1'b0;
      else if (expire_evt)                           halt_q <= 1'b1;
      if (do_start)        expired_q <= 1'b0;
      else if (expire_evt) expired_q <= 1'b1;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT:   bus_rdata = cnt_q;
      A_MIN:   bus_rdata = wmin_q;
      A_MAX:   bus_rdata = wmax_q;
      A_CTL:   bus_rdata = {expired_q, {(DW-2){1'b0}}, mode_q};
      A_DIV:   bus_rdata = DW'(div_q);
      default: bus_rdata = '0;
    endcase
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);
  // R6
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> expired_q);
  // R6
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q && !do_start |=> expired_q);
  // R3
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q && !cmd_clr && !do_start |=> $stable(cnt_q));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !wr_cmd |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + DW'(1)));
  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd && !cmd_clr && !cmd_run |=> $stable(running_q) && $stable(expired_q));
endmodule

// File: tb/wdt_magic_tb.sv
module wdt_magic_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        timeout_pulse;

  int n_vec = 0, n_bad = 0, n_pulse = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;
  always @(negedge clk) if (timeout_pulse === 1'b1) n_pulse++;

  wdt_magic u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timeout_pulse(timeout_pulse));

  // {addr, write data, expected readback}
  localparam logic [71:0] VEC [8] = '{
    {8'h04, 32'h0000_0007, 32'h0000_0007},
    {8'h08, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {8'h0C, 32'hFFFF_FFFF, 32'h0000_0001},
    {8'h0C, 32'h0000_0000, 32'h0000_0000},
    {8'h30, 32'h0000_0005, 32'h0000_0005},
    {8'h10, 32'h0000_4352, 32'h0000_0000},
    {8'h00, 32'h0000_1234, 32'h0000_0000},
    {8'h14, 32'h0000_DEAD, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, held;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    foreach (VEC[i]) begin
      rd(VEC[i][71:64], v);
      chk("R1 reset read", v, 32'h0);
    end
    chk("R1 pulse low", {31'b0, timeout_pulse}, 32'h0);

    // R2 R11 register map table
    foreach (VEC[i]) begin
      cyc(1);
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R2 R11 readback", v, VEC[i][31:0]);
    end

    // R5 R6 expiry at limit 5, divisor 1
    cyc(1);
    wr(8'h04, 0); wr(8'h30, 1); wr(8'h08, 5); wr(8'h0C, 0);
    wr(8'h10, 32'h5354);
    cyc(4); rd(8'h00, v); chk("R4 count 4", v, 4);
    chk("R5 no pulse yet", {31'b0, timeout_pulse}, 0);
    cyc(1); rd(8'h00, v); chk("R5 count at limit", v, 5);
    chk("R5 pulse high", {31'b0, timeout_pulse}, 1);
    rd(8'h0C, v); chk("R6 expired flag", v, 32'h8000_0000);
    cyc(1); chk("R5 pulse one cycle", {31'b0, timeout_pulse}, 0);
    cyc(3); rd(8'h00, v); chk("R5 count held", v, 5);
    // R7 refresh resumes counting, flag stays sticky
    wr(8'h10, 32'h4352);
    rd(8'h00, v); chk("R7 refresh clears", v, 0);
    cyc(2); rd(8'h00, v); chk("R7 counting resumes", v, 2);
    rd(8'h0C, v); chk("R6 flag sticky after refresh", v, 32'h8000_0000);
    // R3 stop
    wr(8'h08, 1000); wr(8'h0C, 1); wr(8'h10, 32'h5354);
    rd(8'h00, held); cyc(5); rd(8'h00, v); chk("R3 stopped count holds", v, held);
    rd(8'h0C, v); chk("R6 R3 flag and mode", v, 32'h8000_0001);
    // R10 ignored commands while stopped
    wr(8'h10, 32'h1234); wr(8'h10, 32'h0001_4352); wr(8'h0C, 0); wr(8'h10, 32'h5355);
    cyc(3); rd(8'h00, v); chk("R10 bad codes ignored", v, held);
    wr(8'h00, 32'h0); rd(8'h00, v); chk("R11 count write ignored", v, held);

    // R4 divisor 3
    wr(8'h30, 3); wr(8'h10, 32'h5354);
    rd(8'h0C, v); chk("R3 start clears flag", v, 0);
    cyc(5); rd(8'h00, v); chk("R4 div3 at 5", v, 1);
    cyc(1); rd(8'h00, v); chk("R4 div3 at 6", v, 2);
    cyc(3); rd(8'h00, v); chk("R4 div3 at 9", v, 3);
    // R4 divisor 0
    wr(8'h30, 0); wr(8'h10, 32'h5354);
    cyc(4); rd(8'h00, v); chk("R4 div0 one per clock", v, 4);
    // R10 near-miss refresh while running
    wr(8'h10, 32'h4353); rd(8'h00, v); chk("R10 near code no clear", v, 5);

    // R8 window violation
    wr(8'h30, 1); wr(8'h04, 10); wr(8'h10, 32'h5354);
    cyc(3); rd(8'h00, v); chk("R8 count 3", v, 3);
    wr(8'h10, 32'h4352);
    chk("R8 violation pulse", {31'b0, timeout_pulse}, 1);
    rd(8'h00, v); chk("R8 count unchanged", v, 3);
    rd(8'h0C, v); chk("R8 flag set", v, 32'h8000_0000);
    cyc(3); rd(8'h00, v); chk("R8 count held", v, 3);
    // R8 refresh inside window is accepted
    wr(8'h10, 32'h5354);
    cyc(11); wr(8'h10, 32'h4352);
    rd(8'h00, v); chk("R8 in-window refresh", v, 0);
    chk("R8 no pulse in window", {31'b0, timeout_pulse}, 0);
    rd(8'h0C, v); chk("R8 flag clear", v, 0);
    // R9 window disabled
    wr(8'h04, 0); wr(8'h10, 32'h5354); wr(8'h10, 32'h4352);
    chk("R9 no pulse", {31'b0, timeout_pulse}, 0);
    rd(8'h00, v); chk("R9 refresh clears", v, 0);

    // R12 lowered limit without refresh
    wr(8'h08, 1000); wr(8'h10, 32'h5354);
    cyc(20); wr(8'h08, 10);
    chk("R12 no pulse on write", {31'b0, timeout_pulse}, 0);
    cyc(1); chk("R12 expires next step", {31'b0, timeout_pulse}, 1);
    rd(8'h00, v); chk("R12 count", v, 22);
    // R12 refresh before lowering
    wr(8'h08, 1000); wr(8'h10, 32'h5354);
    cyc(20); wr(8'h10, 32'h4352); wr(8'h08, 10);
    cyc(5); rd(8'h00, v); chk("R12 safe count", v, 6);
    chk("R12 safe no pulse", {31'b0, timeout_pulse}, 0);
    rd(8'h0C, v); chk("R12 safe flag clear", v, 0);

    cyc(1); #1;
    chk("R5 total pulses", n_pulse, 3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule